// File: doc/BRIEF.md
# T1 Framing Bit Error Monitor

This block watches the framing bit of each received T1 frame once frame alignment has been found elsewhere. For every frame strobe it decides, from the operating mode and a few control bits, whether that frame's framing bit is monitored. If it is, the block compares the bit with the value the frame position calls for. Each mismatch on a monitored bit increments a saturating error counter. Mismatches also enter a short history of recent monitored bits, and when two of the most recent 4, 5 or 6 entries are errors, the block emits a one-cycle reframe request.

Software can also force a reframe request directly. It can also start a multiframe realignment, which raises a signalling freeze flag and leaves terminal frame alignment alone. After any reframe request, monitoring stops and the history is emptied. Monitoring resumes only after the external in-sync flag has gone low and come back high. All outputs are registered and change on the clock edge that samples the strobe.

Top module: `t1_fbit_monitor`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `err_count` is 0 and `reframe_req` and `sig_freeze` are 0.
- R2: In D4 (`mode` 00, or 11, which behaves the same) with 0-based `frame_idx` 0..11, even indices carry terminal bits. Their expected values for index 0,2,4,6,8,10 are 1,0,1,0,1,0. Each mismatch on a monitored bit increments `err_count`. Indices 12 and above are not monitored.
- R3: `reframe_sel` 00, 01 and 10 request a reframe when, after the current monitored bit enters the history, at least 2 of the newest 4, 5 or 6 monitored bits are errors.
- R4: With `reframe_sel` 11, errors are still counted, but no reframe request arises from them.
- R5: Odd D4 indices carry signalling-frame bits with expected values 0,0,1,1,1,0 for index 1,3,5,7,9,11. They are monitored only when `fs_include` is 1 and the mode is D4. In ESF, `fs_include` has no effect.
- R6: With `fs_include` set, the bit of index 11 (frame 12) is monitored only while `sec_yellow` is 0.
- R7: In SLC96 (`mode` 01), only the terminal bits are monitored, whatever the value of `fs_include`.
- R8: In ESF (`mode` 10), only indices 3,7,11,15,19,23 are monitored, with expected values 0,0,1,0,1,1. All other indices are ignored.
- R9: A high `reframe_cmd` produces `reframe_req` on the next cycle whatever the history holds, and the history is emptied.
- R10: After a reframe request, no bit is monitored until `in_sync` has been seen low and then high.
- R11: `err_count` is 8 bits wide and holds at 255. A high `cnt_clear` sets it to 0 on the next cycle, and the clear takes priority over an increment in the same cycle.
- R12: In D4 or SLC96, `mf_reframe_cmd` sets `sig_freeze`. A rising edge of `mf_sync` clears it. Neither action produces `reframe_req`. In ESF, `mf_reframe_cmd` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | One cycle per received frame |
| rx_fbit | input | 1 | Received framing bit, valid with the strobe |
| frame_idx | input | 5 | 0-based frame position within the superframe |
| mode | input | 2 | 00 D4, 01 SLC96, 10 ESF, 11 as D4 |
| in_sync | input | 1 | Terminal frame alignment reported by the frame search |
| fs_include | input | 1 | Monitor signalling-frame bits in D4 |
| sec_yellow | input | 1 | Excludes frame 12's bit when high |
| reframe_sel | input | 2 | History length select / disable |
| reframe_cmd | input | 1 | Force a reframe request |
| mf_reframe_cmd | input | 1 | Start a multiframe realignment |
| mf_sync | input | 1 | Multiframe alignment reported |
| cnt_clear | input | 1 | Clear the error counter |
| err_count | output | 8 | Saturating framing error count |
| reframe_req | output | 1 | One-cycle reframe request |
| sig_freeze | output | 1 | Signalling freeze flag |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 6-entry history with a minimum length of 4, and a 5-bit frame index. These values cover all three history lengths and the disabled setting. The 8-bit counter lets about 300 errors reach saturation within the bench's run. The 5-bit index covers the full 24-frame ESF superframe and the D4 frames beyond index 11. The bench also places error spacings just inside and just outside each history length.

// File: rtl/t1fm_pkg.sv
package t1fm_pkg;
  typedef enum logic [1:0] {
    MODE_D4     = 2'b00,
    MODE_SLC96  = 2'b01,
    MODE_ESF    = 2'b10,
    MODE_D4_ALT = 2'b11
  } fmode_t;

  // bit k holds the expected value of the k-th slot of each pattern
  localparam logic [5:0] TERM_PAT = 6'b010101;
  localparam logic [5:0] SIG_PAT  = 6'b011100;
  localparam logic [5:0] FPS_PAT  = 6'b110100;
endpackage

// File: rtl/t1fm_expect.sv
module t1fm_expect
  import t1fm_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int SF_D4  = 12,
  parameter int SF_ESF = 24
) (
  input  fmode_t           mode,
  input  logic [IDX_W-1:0] idx,
  input  logic             fs_include,
  input  logic             sec_yellow,
  output logic             exp_bit,
  output logic             monitored
);
  localparam int LAST_D4 = SF_D4 - 1;

  logic is_esf, is_d4;
  assign is_esf = (mode == MODE_ESF);
  assign is_d4  = (mode == MODE_D4) || (mode == MODE_D4_ALT);

  always_comb begin
    exp_bit   = 1'b0;
    monitored = 1'b0;
    if (is_esf) begin
      monitored = (idx[1:0] == 2'b11) && (int'(idx) < SF_ESF);
      exp_bit   = FPS_PAT[idx[4:2]];
    end else if (int'(idx) < SF_D4) begin
      if (!idx[0]) begin
        monitored = 1'b1;
        exp_bit   = TERM_PAT[idx[3:1]];
      end else begin
        monitored = is_d4 && fs_include &&
                    !((int'(idx) == LAST_D4) && sec_yellow);
        exp_bit   = SIG_PAT[idx[3:1]];
      end
    end
  end
endmodule

// File: rtl/t1fm_window.sv
module t1fm_window #(
  parameter int WIN_MAX = 6,
  parameter int WIN_MIN = 4,
  parameter int THRESH  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shift,
  input  logic       err_bit,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       hit
);
  localparam int SUM_W = $clog2(WIN_MAX + 1);

  logic [WIN_MAX-1:0] win_q, win_next, masked;
  logic [SUM_W-1:0]   err_sum;

  assign win_next = {win_q[WIN_MAX-2:0], err_bit};

  for (genvar g = 0; g < WIN_MAX; g++) begin : g_mask
    assign masked[g] = (g < WIN_MIN + int'(sel)) ? win_next[g] : 1'b0;
  end

  always_comb begin
    err_sum = '0;
    for (int i = 0; i < WIN_MAX; i++)
      err_sum = err_sum + SUM_W'(masked[i]);
  end

  assign hit = shift && (sel != 2'b11) && (int'(err_sum) >= THRESH);

  always_ff @(posedge clk) begin
    if (rst || clr)   win_q <= '0;
    else if (shift)   win_q <= win_next;
  end

  AST_WIN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (win_q == '0)); // R9
endmodule

// File: rtl/t1fm_errcnt.sv
module t1fm_errcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)                    count <= '0;
    else if (inc && count != CNT_MAX)  count <= count + 1'b1;
  end

  AST_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    (!clr && count == CNT_MAX) |=> (count == CNT_MAX)); // R11
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0)); // R11
endmodule

// File: rtl/t1_fbit_monitor.sv
module t1_fbit_monitor
  import t1fm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 5,
  parameter int WIN_MAX = 6,
  parameter int WIN_MIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_strobe,
  input  logic             rx_fbit,
  input  logic [IDX_W-1:0] frame_idx,
  input  logic [1:0]       mode,
  input  logic             in_sync,
  input  logic             fs_include,
  input  logic             sec_yellow,
  input  logic [1:0]       reframe_sel,
  input  logic             reframe_cmd,
  input  logic             mf_reframe_cmd,
  input  logic             mf_sync,
  input  logic             cnt_clear,
  output logic [CNT_W-1:0] err_count,
  output logic             reframe_req,
  output logic             sig_freeze
);
  fmode_t mode_e;
  logic   exp_bit, monitored, mon_en, bit_err, hit, req_next;
  logic   paused_q, mfs_q;

  assign mode_e = fmode_t'(mode);

  t1fm_expect #(.IDX_W(IDX_W)) u_expect (
    .mode(mode_e), .idx(frame_idx), .fs_include(fs_include),
    .sec_yellow(sec_yellow), .exp_bit(exp_bit), .monitored(monitored));

  assign mon_en   = frame_strobe && in_sync && !paused_q && monitored;
  assign bit_err  = rx_fbit ^ exp_bit;
  assign req_next = reframe_cmd || hit;

  t1fm_window #(.WIN_MAX(WIN_MAX), .WIN_MIN(WIN_MIN), .THRESH(2)) u_window (
    .clk(clk), .rst(rst), .shift(mon_en), .err_bit(bit_err),
    .clr(req_next), .sel(reframe_sel), .hit(hit));

  t1fm_errcnt #(.CNT_W(CNT_W)) u_errcnt (
    .clk(clk), .rst(rst), .inc(mon_en && bit_err), .clr(cnt_clear),
    .count(err_count));

  always_ff @(posedge clk) begin
    if (rst) begin
      reframe_req <= 1'b0;
      paused_q    <= 1'b0;
      sig_freeze  <= 1'b0;
      mfs_q       <= 1'b0;
    end else begin
      reframe_req <= req_next;
      if (req_next)      paused_q <= 1'b1;
      else if (!in_sync) paused_q <= 1'b0;
      mfs_q <= mf_sync;
      if (mf_reframe_cmd && mode_e != MODE_ESF) sig_freeze <= 1'b1;
      else if (mf_sync && !mfs_q)               sig_freeze <= 1'b0;
    end
  end

  AST_CMD_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    reframe_cmd |=> reframe_req); // R9
  AST_NO_AUTO_REFRAME: assert property (@(posedge clk) disable iff (rst)
    (reframe_sel == 2'b11 && !reframe_cmd) |=> !reframe_req); // R4
  AST_PAUSED_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (paused_q && !cnt_clear) |=> (err_count == $past(err_count))); // R10
  AST_ESF_NO_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_ESF && !sig_freeze) |=> !sig_freeze); // R12
endmodule

// File: tb/test_t1_fbit_monitor.sv
`timescale 1ns/1ps
module test_t1_fbit_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_strobe = 0, rx_fbit = 0, in_sync = 0, fs_include = 0;
  logic       sec_yellow = 0, reframe_cmd = 0, mf_reframe_cmd = 0;
  logic       mf_sync = 0, cnt_clear = 0;
  logic [4:0] frame_idx = '0;
  logic [1:0] mode = 2'b00, reframe_sel = 2'b00;
  logic [7:0] err_count;
  logic       reframe_req, sig_freeze;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit started = 0, req_seen = 0;

  always #2.5 clk = ~clk;

  t1_fbit_monitor i_t1_fbit_monitor (.*);

  // ---------------- behavioural reference ----------------
  int ft[6]  = '{1,0,1,0,1,0};
  int fs[6]  = '{0,0,1,1,1,0};
  int fps[6] = '{0,0,1,0,1,1};
  int m_cnt = 0, hist[$];
  bit m_req = 0, m_frz = 0, m_paused = 0, m_mfq = 0;

  function automatic int raw_exp(int idx);
    if (mode == 2'b10) return fps[(idx/4) % 6];
    return (idx % 2 == 0) ? ft[(idx/2) % 6] : fs[(idx/2) % 6];
  endfunction

  function automatic bit is_mon(int idx);
    int n = idx + 1;
    if (mode == 2'b10) return (n % 4 == 0) && n <= 24;
    if (n > 12) return 0;
    if (n % 2 == 1) return 1;
    return (mode != 2'b01) && fs_include && !(n == 12 && sec_yellow);
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_cnt = 0; m_req = 0; m_frz = 0; m_paused = 0; m_mfq = 0;
      hist.delete();
    end else begin
      bit mon, e, hitm;
      int errs, nwin;
      mon  = frame_strobe && in_sync && !m_paused && is_mon(frame_idx);
      e    = mon && (rx_fbit != raw_exp(frame_idx));
      hitm = 0;
      if (e && m_cnt < 255) m_cnt++;
      if (cnt_clear) m_cnt = 0;
      if (mon) begin
        hist.push_back(int'(rx_fbit != raw_exp(frame_idx)));
        while (hist.size() > 6) void'(hist.pop_front());
        nwin = 4 + reframe_sel;
        errs = 0;
        for (int i = hist.size() - 1; i >= 0 && i >= hist.size() - nwin; i--)
          errs += hist[i];
        hitm = (errs >= 2) && (reframe_sel != 2'b11);
      end
      m_req = reframe_cmd || hitm;
      if (m_req) begin hist.delete(); m_paused = 1; end
      else if (!in_sync) m_paused = 0;
      if (mf_reframe_cmd && mode != 2'b10) m_frz = 1;
      else if (mf_sync && !m_mfq) m_frz = 0;
      m_mfq = mf_sync;
    end
  end

  always @(negedge clk) if (started) begin
    n_cmp++;
    if (err_count !== 8'(m_cnt) || reframe_req !== m_req || sig_freeze !== m_frz) begin
      n_bad++;
      $display("FAIL %s per-cycle: cnt=%0d req=%0b frz=%0b expected cnt=%0d req=%0b frz=%0b",
               cur_req, err_count, reframe_req, sig_freeze, m_cnt, m_req, m_frz);
    end
    if (reframe_req) req_seen = 1;
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string r, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] md, logic [1:0] sel);
    @(negedge clk);
    rst = 1; mode = md; reframe_sel = sel; fs_include = 0; sec_yellow = 0;
    in_sync = 1; mf_sync = 0;
    idle(2);
    rst = 0;
    req_seen = 0;
  endtask

  task automatic send(int idx, int err);
    @(negedge clk);
    frame_strobe = 1; frame_idx = 5'(idx); rx_fbit = 1'(raw_exp(idx) ^ err);
    @(negedge clk);
    frame_strobe = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    do_reset(2'b00, 2'b00);
    chk("R1 count", err_count, 0);
    chk("R1 req", reframe_req, 0);
    chk("R1 freeze", sig_freeze, 0);

    // R2 clean D4 superframe, then single terminal error, index beyond 11
    cur_req = "R2";
    for (int i = 0; i < 12; i++) send(i, 0);
    chk("R2 clean", err_count, 0);
    send(4, 1);
    chk("R2 one error", err_count, 1);
    send(14, 1);
    chk("R2 idx 14 ignored", err_count, 1);

    // R3 spacing against history lengths
    cur_req = "R3";
    do_reset(2'b00, 2'b00);
    send(0,1); send(2,0); send(4,0); send(6,0); send(8,1); idle(2);
    chk("R3 sel00 span5 no req", req_seen, 0);
    chk("R3 sel00 count", err_count, 2);
    do_reset(2'b00, 2'b01);
    send(0,1); send(2,0); send(4,0); send(6,0); send(8,1); idle(2);
    chk("R3 sel01 span5 req", req_seen, 1);
    do_reset(2'b00, 2'b01);
    send(0,1); send(2,0); send(4,0); send(6,0); send(8,0); send(10,1); idle(2);
    chk("R3 sel01 span6 no req", req_seen, 0);
    do_reset(2'b00, 2'b10);
    send(0,1); send(2,0); send(4,0); send(6,0); send(8,0); send(10,1); idle(2);
    chk("R3 sel10 span6 req", req_seen, 1);

    // R4 disabled reframe
    cur_req = "R4";
    do_reset(2'b00, 2'b11);
    for (int i = 0; i < 6; i++) send(2*i, 1);
    idle(2);
    chk("R4 no req", req_seen, 0);
    chk("R4 counted", err_count, 6);

    // R5 signalling bits in D4 only
    cur_req = "R5";
    do_reset(2'b00, 2'b11);
    send(1, 1);
    chk("R5 fs excluded", err_count, 0);
    fs_include = 1;
    send(1, 1);
    chk("R5 fs included", err_count, 1);
    do_reset(2'b10, 2'b11);
    fs_include = 1;
    send(1, 1); send(5, 1);
    chk("R5 esf no effect", err_count, 0);

    // R6 frame 12 with secondary yellow
    cur_req = "R6";
    do_reset(2'b00, 2'b11);
    fs_include = 1; sec_yellow = 1;
    send(11, 1);
    chk("R6 frame12 skipped", err_count, 0);
    sec_yellow = 0;
    send(11, 1);
    chk("R6 frame12 counted", err_count, 1);

    // R7 SLC96
    cur_req = "R7";
    do_reset(2'b01, 2'b11);
    fs_include = 1;
    send(3, 1); send(11, 1);
    chk("R7 slc96 fs ignored", err_count, 0);
    send(0, 1);
    chk("R7 slc96 ft counted", err_count, 1);

    // R8 ESF FPS positions
    cur_req = "R8";
    do_reset(2'b10, 2'b11);
    for (int i = 0; i < 24; i++) send(i, 0);
    chk("R8 clean esf", err_count, 0);
    send(0, 1); send(2, 1);
    chk("R8 non-fps ignored", err_count, 0);
    send(3, 1); send(23, 1);
    chk("R8 fps counted", err_count, 2);

    // R9 forced reframe; R10 pause
    cur_req = "R9";
    do_reset(2'b00, 2'b11);
    pulse(reframe_cmd); idle(1);
    chk("R9 forced req", req_seen, 1);
    cur_req = "R10";
    send(0, 1);
    chk("R10 paused no count", err_count, 0);
    @(negedge clk); in_sync = 0;
    @(negedge clk); in_sync = 1;
    send(0, 1);
    chk("R10 resumed", err_count, 1);

    // R11 saturation and clear
    cur_req = "R11";
    do_reset(2'b00, 2'b11);
    for (int i = 0; i < 300; i++) send(0, 1);
    chk("R11 saturated", err_count, 255);
    @(negedge clk); cnt_clear = 1; frame_strobe = 1; frame_idx = 0; rx_fbit = 0;
    @(negedge clk); cnt_clear = 0; frame_strobe = 0;
    chk("R11 clear wins", err_count, 0);

    // R12 multiframe freeze
    cur_req = "R12";
    do_reset(2'b00, 2'b00);
    pulse(mf_reframe_cmd);
    chk("R12 freeze set", sig_freeze, 1);
    idle(2);
    chk("R12 no reframe", req_seen, 0);
    @(negedge clk); mf_sync = 1;
    @(negedge clk);
    chk("R12 released", sig_freeze, 0);
    do_reset(2'b10, 2'b00);
    pulse(mf_reframe_cmd); idle(1);
    chk("R12 esf ignored", sig_freeze, 0);

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule